// File: doc/BRIEF.md
# Effective address sequencer

This block forms the operand address of an 8-bit processor instruction one clock at a time, on a 13-bit address space. After the opcode has been consumed, the controller gives it an addressing mode, the index register value and a start pulse. The sequencer reads the operand bytes at the program counter it holds, moving the counter forward after each byte. It then combines those bytes with the index or with the counter and ends with a one-clock ready pulse. The result stays on `ea_o` until the next accepted start.

Seven modes are supported: immediate, zero-page direct, two-byte extended, indexed with no offset, indexed with an 8-bit offset, indexed with a 16-bit offset, and relative. A relative offset is sign-extended and added to the address of the byte after the offset, which is the opcode address plus two. An eighth mode code reads nothing and reports at once. All address arithmetic is modulo 2^13. When an operand byte sets the high address part, only its low 5 bits are used.

Top module: `ea_sequencer`

## Requirements
- R1: While reset is held and after it is released, `ready_o`, `busy_o` and `mem_rd_o` are 0, and `pc_o` and `ea_o` are 0.
- R2: `pc_ld_i` loads `pc_ld_val_i` into `pc_o` on the next clock. Each operand byte is read with `mem_rd_o` high and `mem_addr_o` equal to `pc_o`, and `pc_o` then advances by one, wrapping from 0x1FFF to 0x0000.
- R3: Mode code 0 (immediate) reads one byte, places it on `data_o`, leaves `ea_o` at 0 and raises `ready_o` in the 2nd cycle after the edge that accepts start.
- R4: Mode code 1 (direct) reads one byte b and gives `ea_o` = {5'b0, b}. Ready comes in the 2nd cycle.
- R5: Mode code 2 (extended) reads the high byte and then the low byte. Bits 7:5 of the high byte are dropped. Ready comes in the 3rd cycle.
- R6: Mode code 3 (indexed, no offset) performs no memory read, leaves `pc_o` unchanged and gives `ea_o` = X zero-extended. Ready comes in the 2nd cycle.
- R7: Mode code 4 (indexed, 8-bit offset) reads one byte b and gives `ea_o` = b + X mod 2^13. Ready comes in the 3rd cycle.
- R8: Mode code 5 (indexed, 16-bit offset) reads the high and then the low byte and gives `ea_o` = {hi[4:0], lo} + X mod 2^13. Ready comes in the 4th cycle. No operation keeps `busy_o` high for more than 4 cycles.
- R9: Mode code 6 (relative) reads one offset byte at address P and gives `ea_o` = P + 1 + sign_extend(offset) mod 2^13. Ready comes in the 3rd cycle.
- R10: Mode code 7 reads nothing, leaves `pc_o` unchanged, gives `ea_o` = 0 and raises `ready_o` in the 1st cycle.
- R11: `ready_o` is high for exactly one cycle per accepted start. `ea_o` then holds while idle, whatever `x_i`, `mode_i` and memory do.
- R12: A start is accepted only while `busy_o` is 0. A start during a busy operation produces no further result and does not disturb the running one. X is captured when start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin an address sequence (accepted when idle) |
| mode_i | input | 3 | Addressing mode code 0..7 |
| x_i | input | 8 | Index register value |
| pc_ld_i | input | 1 | Load the program counter |
| pc_ld_val_i | input | 13 | Value loaded into the program counter |
| mem_rd_o | output | 1 | Operand byte read strobe |
| mem_addr_o | output | 13 | Read address (the program counter) |
| mem_data_i | input | 8 | Read data, valid in the same cycle as the address |
| pc_o | output | 13 | Current program counter |
| ea_o | output | 13 | Effective address or branch target |
| data_o | output | 8 | Immediate operand byte |
| busy_o | output | 1 | A sequence is in progress |
| ready_o | output | 1 | One-cycle result pulse |

## Verification
The bench builds the block with its default 13-bit address and 8-bit data widths. At those widths the 5-bit high-byte truncation, the carry wrap of an indexed sum past 0x1FFF, a negative branch offset that wraps below 0x0000 and a counter that wraps between the two bytes of an extended operand all fall within reach of a few hand-chosen operands. It also drives start pulses into busy sequences and changes the index value right after acceptance, so the capture and ignore rules are checked at the ports.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;

  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_DIR  = 3'd1,
    AM_EXT  = 3'd2,
    AM_IX0  = 3'd3,
    AM_IX1  = 3'd4,
    AM_IX2  = 3'd5,
    AM_REL  = 3'd6,
    AM_NONE = 3'd7
  } am_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_HI   = 3'd1,
    S_LO   = 3'd2,
    S_ADD  = 3'd3,
    S_DONE = 3'd4
  } st_e;

  // First step taken after a start is accepted
  function automatic st_e first_step(input am_e m);
    case (m)
      AM_EXT, AM_IX2:                  first_step = S_HI;
      AM_IMM, AM_DIR, AM_IX1, AM_REL:  first_step = S_LO;
      AM_IX0:                          first_step = S_ADD;
      default:                         first_step = S_DONE;
    endcase
  endfunction

  // Whether an add step follows the last operand byte
  function automatic logic needs_add(input am_e m);
    needs_add = (m == AM_IX1) || (m == AM_IX2) || (m == AM_REL);
  endfunction

endpackage

// File: rtl/ea_seq_ctrl.sv
module ea_seq_ctrl
  import ea_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  am_e  mode_i,
  output st_e  st_q,
  output am_e  mode_q,
  output logic accept_o,
  output logic fetch_hi_o,
  output logic fetch_lo_o,
  output logic add_o,
  output logic done_o
);

  st_e st_d;
  am_e mode_d;

  assign accept_o   = (st_q == S_IDLE) && start_i;
  assign fetch_hi_o = (st_q == S_HI);
  assign fetch_lo_o = (st_q == S_LO);
  assign add_o      = (st_q == S_ADD);
  assign done_o     = (st_q == S_DONE);

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          mode_d = mode_i;
          st_d   = first_step(mode_i);
        end
      end
      S_HI:   st_d = S_LO;
      S_LO:   st_d = needs_add(mode_q) ? S_ADD : S_DONE;
      S_ADD:  st_d = S_DONE;
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      mode_q <= AM_IMM;
    end else begin
      st_q <= st_d;
      if (accept_o) mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/ea_seq_pc.sv
module ea_seq_pc #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] pc_q
);

  logic              pc_en;
  logic [ADDR_W-1:0] pc_d;

  assign pc_en = ld_i || inc_i;

  always_comb begin
    if (ld_i) pc_d = ld_val_i;
    else      pc_d = pc_q + {{(ADDR_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

endmodule

// File: rtl/ea_seq_adder.sv
module ea_seq_adder #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              sel_pc_i,
  output logic [ADDR_W-1:0] sum_o
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addend;

  generate
    if (HI_W > 0) begin : g_zext
      assign addend = sel_pc_i ? pc_i : {{HI_W{1'b0}}, x_i};
    end else begin : g_trunc
      assign addend = sel_pc_i ? pc_i : x_i[ADDR_W-1:0];
    end
  endgenerate

  // Carry beyond the address width is discarded
  assign sum_o = base_i + addend;

endmodule

// File: rtl/ea_seq_mar.sv
module ea_seq_mar
  import ea_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] x_i,
  input  am_e               mode_q,
  input  logic              fetch_hi_i,
  input  logic              fetch_lo_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [ADDR_W-1:0] sum_i,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] x_q,
  output logic [DATA_W-1:0] imm_q
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] mar_d;
  logic              mar_en;
  logic              imm_en;
  logic [ADDR_W-1:0] sext_off;

  assign sext_off = {{HI_W{rd_data_i[DATA_W-1]}}, rd_data_i};
  assign imm_en   = fetch_lo_i && (mode_q == AM_IMM);
  assign mar_en   = accept_i || fetch_hi_i || (fetch_lo_i && !imm_en) || add_i;

  always_comb begin
    mar_d = mar_q;
    if (accept_i) begin
      mar_d = '0;
    end else if (fetch_hi_i) begin
      mar_d[ADDR_W-1:DATA_W] = rd_data_i[HI_W-1:0];
    end else if (fetch_lo_i) begin
      if (mode_q == AM_REL) mar_d = sext_off;
      else                  mar_d[DATA_W-1:0] = rd_data_i;
    end else if (add_i) begin
      mar_d = sum_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      x_q   <= '0;
      imm_q <= '0;
    end else begin
      if (mar_en)   mar_q <= mar_d;
      if (accept_i) x_q   <= x_i;
      if (imm_en)   imm_q <= rd_data_i;
    end
  end

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic              pc_ld_i,
  input  logic [ADDR_W-1:0] pc_ld_val_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic              ready_o
);

  logic rst_meta_n;
  logic rst_sync_n;

  // Reset asserts at once and releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  st_e               st_q;
  am_e               mode_q;
  logic              accept;
  logic              fetch_hi;
  logic              fetch_lo;
  logic              add_step;
  logic              done;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] x_q;
  logic [DATA_W-1:0] imm_q;
  logic [ADDR_W-1:0] sum;

  ea_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .mode_i     (am_e'(mode_i)),
    .st_q       (st_q),
    .mode_q     (mode_q),
    .accept_o   (accept),
    .fetch_hi_o (fetch_hi),
    .fetch_lo_o (fetch_lo),
    .add_o      (add_step),
    .done_o     (done)
  );

  ea_seq_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ld_i     (pc_ld_i),
    .ld_val_i (pc_ld_val_i),
    .inc_i    (fetch_hi || fetch_lo),
    .pc_q     (pc_q)
  );

  ea_seq_adder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_add (
    .base_i   (mar_q),
    .x_i      (x_q),
    .pc_i     (pc_q),
    .sel_pc_i (mode_q == AM_REL),
    .sum_o    (sum)
  );

  ea_seq_mar #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mar (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept_i   (accept),
    .x_i        (x_i),
    .mode_q     (mode_q),
    .fetch_hi_i (fetch_hi),
    .fetch_lo_i (fetch_lo),
    .add_i      (add_step),
    .rd_data_i  (mem_data_i),
    .sum_i      (sum),
    .mar_q      (mar_q),
    .x_q        (x_q),
    .imm_q      (imm_q)
  );

  assign mem_rd_o   = fetch_hi || fetch_lo;
  assign mem_addr_o = pc_q;
  assign pc_o       = pc_q;
  assign ea_o       = mar_q;
  assign data_o     = imm_q;
  assign busy_o     = (st_q != S_IDLE);
  assign ready_o    = done;

endmodule

// File: rtl/ea_seq_chk.sv
module ea_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              pc_ld_i,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] ea_o,
  input logic              busy_o,
  input logic              ready_o,
  input logic [2:0]        mode_q
);

  logic [2:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run <= '0;
    else if (busy_o) busy_run <= (busy_run == 3'd7) ? busy_run : busy_run + 3'd1;
    else             busy_run <= '0;
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !pc_ld_i) |=> (pc_o == $past(pc_o) + {{(ADDR_W-1){1'b0}}, 1'b1})); // R2

  AST_IX0_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q == 3'd3) |-> !mem_rd_o); // R6

  AST_DIR_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && mode_q == 3'd1) |-> (ea_o[ADDR_W-1:8] == '0)); // R4

  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_run < 3'd4)); // R8

  AST_NONE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q == 3'd7) |-> !mem_rd_o); // R10

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o); // R11

  AST_EA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o || (!busy_o && !start_i)) |=> $stable(ea_o)); // R11

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_rd_o); // R12

endmodule

bind ea_sequencer ea_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start_i  (start_i),
  .pc_ld_i  (pc_ld_i),
  .mem_rd_o (mem_rd_o),
  .pc_o     (pc_o),
  .ea_o     (ea_o),
  .busy_o   (busy_o),
  .ready_o  (ready_o),
  .mode_q   (mode_q)
);

// File: tb/sim_ea_sequencer.sv
module sim_ea_sequencer;

  localparam int AW = 13;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [2:0]    mode_i;
  logic [DW-1:0] x_i;
  logic          pc_ld_i;
  logic [AW-1:0] pc_ld_val_i;
  logic          mem_rd_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_data_i;
  logic [AW-1:0] pc_o;
  logic [AW-1:0] ea_o;
  logic [DW-1:0] data_o;
  logic          busy_o;
  logic          ready_o;

  always #5 clk = ~clk;

  ea_sequencer #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .x_i(x_i),
    .pc_ld_i(pc_ld_i), .pc_ld_val_i(pc_ld_val_i), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i), .pc_o(pc_o), .ea_o(ea_o),
    .data_o(data_o), .busy_o(busy_o), .ready_o(ready_o)
  );

  // Small memory window addressed by the low six address bits
  logic [DW-1:0] img [0:63];
  assign mem_data_i = img[mem_addr_o[5:0]];

  typedef struct packed {
    logic [AW-1:0] ea;
    logic [AW-1:0] pc;
    logic [DW-1:0] data;
    logic [2:0]    md;
    logic [31:0]   t0;
    logic [31:0]   rd0;
    logic [31:0]   lat;
    logic [31:0]   nrd;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int   n_run = 0;
  int   n_fail = 0;
  int   cyc = 0;
  int   rd_cnt = 0;
  bit   ready_prev = 1'b0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic string req_of(input logic [2:0] md);
    case (md)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_ea(input logic [2:0] md, input logic [AW-1:0] pc0,
                                           input logic [7:0] x, input logic [7:0] b0,
                                           input logic [7:0] b1);
    logic [AW-1:0] r;
    case (md)
      3'd1: r = {5'b0, b0};
      3'd2: r = {b0[4:0], b1};
      3'd3: r = {5'b0, x};
      3'd4: r = {5'b0, b0} + {5'b0, x};
      3'd5: r = {b0[4:0], b1} + {5'b0, x};
      3'd6: r = pc0 + 13'd1 + {{5{b0[7]}}, b0};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic int exp_bytes(input logic [2:0] md);
    case (md)
      3'd0, 3'd1, 3'd4, 3'd6: return 1;
      3'd2, 3'd5:             return 2;
      default:                return 0;
    endcase
  endfunction

  function automatic int exp_lat(input logic [2:0] md);
    case (md)
      3'd2, 3'd4, 3'd6: return 3;
      3'd5:             return 4;
      3'd7:             return 1;
      default:          return 2;
    endcase
  endfunction

  // Monitor: read counter and result scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_o) rd_cnt = rd_cnt + 1;
      if (ready_o) begin
        if (ready_prev) chk(1'b0, "R11", "ready wider than one cycle", 32'd1, 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12", "result with no accepted start", 32'd1, 32'd0);
        end else begin
          cur = exp_q.pop_front();
          chk(ea_o == cur.ea, req_of(cur.md), "ea", 32'(ea_o), 32'(cur.ea));
          chk(pc_o == cur.pc, "R2", "pc after operand", 32'(pc_o), 32'(cur.pc));
          chk(32'(cyc) - cur.t0 == cur.lat, req_of(cur.md), "latency",
              32'(cyc) - cur.t0, cur.lat);
          chk(32'(rd_cnt) - cur.rd0 == cur.nrd, req_of(cur.md), "operand reads",
              32'(rd_cnt) - cur.rd0, cur.nrd);
          if (cur.md == 3'd0)
            chk(data_o == cur.data, "R3", "immediate byte", 32'(data_o), 32'(cur.data));
        end
      end
      ready_prev = ready_o;
    end
  end

  task automatic issue(input logic [2:0] md, input logic [AW-1:0] pc0, input logic [7:0] x,
                       input logic [7:0] b0, input logic [7:0] b1, input bit poke);
    exp_t e;
    logic [AW-1:0] pc1;
    pc1 = pc0 + 13'd1;
    @(negedge clk);
    pc_ld_i     = 1'b1;
    pc_ld_val_i = pc0;
    img[pc0[5:0]] = b0;
    img[pc1[5:0]] = b1;
    @(negedge clk);
    pc_ld_i = 1'b0;
    chk(pc_o == pc0, "R2", "pc load", 32'(pc_o), 32'(pc0));
    e.ea   = exp_ea(md, pc0, x, b0, b1);
    e.pc   = pc0 + 13'(exp_bytes(md));
    e.data = b0;
    e.md   = md;
    e.t0   = 32'(cyc);
    e.rd0  = 32'(rd_cnt);
    e.lat  = 32'(exp_lat(md));
    e.nrd  = 32'(exp_bytes(md));
    exp_q.push_back(e);
    mode_i  = md;
    x_i     = x;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    x_i     = ~x;      // R12: X must have been captured at acceptance
    mode_i  = 3'd5;
    if (poke) begin
      start_i = 1'b1;  // R12: start while busy is ignored
      mode_i  = 3'd7;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    // R11: result held while idle despite changing inputs and memory
    x_i = 8'h5A;
    mode_i = 3'd3;
    img[pc0[5:0]] = ~b0;
    img[pc1[5:0]] = ~b1;
    repeat (3) @(negedge clk);
    chk(ea_o == e.ea, "R11", "ea held while idle", 32'(ea_o), 32'(e.ea));
    chk(!busy_o && !ready_o, "R11", "idle with no start", {30'd0, busy_o, ready_o}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) img[i] = 8'h00;
    rst_n = 1'b0; start_i = 1'b0; mode_i = 3'd0; x_i = 8'h00;
    pc_ld_i = 1'b0; pc_ld_val_i = '0;
    repeat (3) @(negedge clk);
    chk({ready_o, busy_o, mem_rd_o} == 3'b000, "R1", "flags in reset",
        {29'd0, ready_o, busy_o, mem_rd_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({ready_o, busy_o, mem_rd_o} == 3'b000, "R1", "flags after reset",
        {29'd0, ready_o, busy_o, mem_rd_o}, 32'd0);
    chk(pc_o == '0 && ea_o == '0, "R1", "pc and ea after reset", 32'({pc_o, ea_o}), 32'd0);

    issue(3'd0, 13'h0040, 8'h11, 8'hA5, 8'h00, 1'b0); // R3
    issue(3'd1, 13'h0123, 8'h22, 8'h9C, 8'h00, 1'b0); // R4
    issue(3'd2, 13'h0200, 8'h33, 8'hE3, 8'h45, 1'b0); // R5 high bits dropped
    issue(3'd2, 13'h1FFF, 8'h00, 8'h0A, 8'h55, 1'b0); // R5, R2 pc wrap between bytes
    issue(3'd3, 13'h0300, 8'hB7, 8'hFF, 8'hFF, 1'b0); // R6
    issue(3'd4, 13'h0310, 8'h35, 8'hF0, 8'h00, 1'b0); // R7
    issue(3'd5, 13'h0400, 8'h10, 8'h12, 8'h34, 1'b0); // R8
    issue(3'd5, 13'h0500, 8'h20, 8'hFF, 8'hF0, 1'b0); // R8 sum wraps to 0x0010
    issue(3'd6, 13'h0100, 8'h00, 8'h80, 8'h00, 1'b0); // R9 most negative offset
    issue(3'd6, 13'h1FFF, 8'h00, 8'h05, 8'h00, 1'b0); // R9 target wraps forward
    issue(3'd6, 13'h0002, 8'h00, 8'hF0, 8'h00, 1'b0); // R9 target wraps backward
    issue(3'd7, 13'h0777, 8'h44, 8'h12, 8'h34, 1'b0); // R10
    issue(3'd4, 13'h0020, 8'hFE, 8'h01, 8'h00, 1'b1); // R12 start while busy
    issue(3'd0, 13'h0030, 8'h00, 8'h3C, 8'h00, 1'b1); // R12, R3
    issue(3'd7, 13'h0031, 8'h00, 8'h00, 8'h00, 1'b1); // R12, R10

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "results outstanding", 32'(exp_q.size()), 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule